// File: doc/BRIEF.md
# UART FIFO Control and Interrupt Identification

This block holds the receive and transmit character queues of a 16550-style UART, together with the control that decides when each queue raises an interrupt, drops the RTS flow-control line, or asks a DMA engine for service. The serial shifters, the baud divisor and line control are outside it. The receive shifter pushes characters in and the host pops them. The host pushes transmit characters and the transmit shifter pops them. Four event inputs carry conditions that other logic detects: a line error, a character timeout pulse, a modem status change and a busy condition.

One register address serves two purposes. A host write to it sets up the queues: an enable bit, a reset for each queue, the DMA signalling style, the receive trigger and the transmit-empty threshold. A host read of the same address returns whether the queues are enabled and a 4-bit code for the most urgent pending interrupt. Writing a new value of the enable bit empties both queues. While the queues are disabled, each one holds a single character.

Top module: `uart_fifo_ctl`

## Requirements
- R1: A read of the shared address returns bits [7:6] = 11 when the queues are enabled and 00 when they are disabled, with bits [5:4] = 00. After reset the read value is 8'h01.
- R2: Read bits [3:0] give the most urgent pending source, using these codes: line error 0110, receive data available 0100, character timeout 1100, transmit holding empty 0010, modem status 0000, busy 0111, nothing pending 0001. The priority order, from highest to lowest, is line error, receive data available, character timeout, transmit empty, modem status, busy.
- R3: A write with bit 1 set empties the receive queue, and a write with bit 2 set empties the transmit queue, starting on the next cycle. Neither bit is stored, so pushes succeed afterwards without writing a 0 to the bit first.
- R4: A write whose bit 0 differs from the current enable state empties both queues. A write that keeps the same bit 0 leaves the queue contents alone unless bit 1 or bit 2 is set.
- R5: Write bits [7:6] choose the receive trigger, which is the receive level at or above which "receive data available" is pending: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14. While the queues are disabled, the trigger is 1.
- R6: Write bits [5:4] choose the transmit-empty threshold: 00 gives 0, 01 gives 2, 10 gives 4, 11 gives 8. "Transmit empty" becomes pending on the cycle after the transmit level moves from above the threshold to at or below it. It is cleared by a read of the shared address that returns code 0010, or by a transmit push.
- R7: A one-cycle timeout pulse makes "character timeout" pending, and it stays pending until a receive pop or a receive queue reset clears it.
- R8: With auto flow control on, rts_n is high while the receive level is at or above the receive trigger, and low otherwise. With auto flow control off, rts_n is low.
- R9: When write bit 3 is 0 (DMA mode 0), dma_rx_req_n is low exactly while the receive queue is not empty, and dma_tx_req_n is low exactly while the transmit queue has space.
- R10: When write bit 3 is 1 (DMA mode 1), dma_rx_req_n goes low once the receive level reaches the trigger and stays low until the queue is empty. dma_tx_req_n goes low once the transmit level is at or below the threshold and stays low until the queue is full.
- R11: Each queue returns characters in first-in first-out order and holds at most 16 entries when enabled and 1 entry when disabled. A push into a full queue and a pop from an empty queue are ignored.
- R12: irq is high exactly when the interrupt code is not 0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe for the shared control address |
| reg_rd | input | 1 | Host read strobe for the shared address |
| reg_wdata | input | 8 | Control value that is written |
| reg_rdata | output | 8 | Enable status and interrupt code |
| tx_wr | input | 1 | Host push into the transmit queue |
| tx_wdata | input | 8 | Transmit character pushed |
| tx_pop | input | 1 | Transmit shifter takes the head character |
| tx_rdata | output | 8 | Head of the transmit queue |
| tx_level | output | 5 | Transmit queue fill level |
| rx_push | input | 1 | Receive shifter pushes a character |
| rx_wdata | input | 8 | Received character |
| rx_rd | input | 1 | Host pops the receive queue |
| rx_rdata | output | 8 | Head of the receive queue |
| rx_level | output | 5 | Receive queue fill level |
| afc_en | input | 1 | Auto flow control enable |
| line_err | input | 1 | Receiver line error condition (level) |
| timeout_evt | input | 1 | Character timeout pulse |
| modem_evt | input | 1 | Modem status change condition (level) |
| busy_evt | input | 1 | Busy condition (level) |
| irq | output | 1 | Interrupt request |
| rts_n | output | 1 | Flow control, high asks the far end to stop |
| dma_tx_req_n | output | 1 | Transmit DMA request, active low |
| dma_rx_req_n | output | 1 | Receive DMA request, active low |

## Verification
The properties assume that a host write and a host read of the shared address never fall in the same cycle, and that a timeout pulse never coincides with a receive pop. They also assume that line error, modem and busy are levels held by the surrounding logic rather than pulses. The stimulus drives every strobe for exactly one cycle through dedicated tasks, so these conditions never overlap. It raises the event inputs only between host operations. It also keeps a model of queue occupancy, so that characters dropped on a full queue are left out of the scoreboard.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    typedef enum logic [3:0] {
        IID_MODEM = 4'b0000,
        IID_NONE  = 4'b0001,
        IID_THRE  = 4'b0010,
        IID_RDA   = 4'b0100,
        IID_RLS   = 4'b0110,
        IID_BUSY  = 4'b0111,
        IID_CTO   = 4'b1100
    } iid_e;

    // Layout of a control write, MSB first.
    typedef struct packed {
        logic [1:0] rx_trig;
        logic [1:0] tx_thr;
        logic       dma_mode;
        logic       tx_clr;
        logic       rx_clr;
        logic       enable;
    } fcr_t;

    function automatic int unsigned rx_trig_count(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'b00:   return 1;
            2'b01:   return depth / 4;
            2'b10:   return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

    function automatic int unsigned tx_thr_count(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'b00:   return 0;
            2'b01:   return 2;
            2'b10:   return depth / 4;
            default: return depth / 2;
        endcase
    endfunction

endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cap_one,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [LW-1:0]    level
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [LW-1:0]    cnt, cap;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cap     = cap_one ? LW'(1) : LW'(DEPTH);
    assign do_push = push && (cnt < cap);
    assign do_pop  = pop && (cnt != '0);
    assign rdata   = mem[rptr];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= step(wptr);
            if (do_pop)  rptr <= step(rptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wptr] <= wdata;
    end
endmodule

// File: rtl/ufc_dma.sv
module ufc_dma #(
    parameter int DEPTH = 16,
    parameter bit IS_RX = 1'b1,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          mode1,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] thresh,
    input  logic [LW-1:0] cap,
    output logic          req_n
);
    logic start, stop, avail, hold_q, req_m1;

    generate
        if (IS_RX) begin : g_rx
            assign start = level >= thresh;
            assign stop  = level == '0;
            assign avail = level != '0;
        end else begin : g_tx
            assign start = level <= thresh;
            assign stop  = level >= cap;
            assign avail = level < cap;
        end
    endgenerate

    assign req_m1 = start || (hold_q && !stop);
    assign req_n  = !(mode1 ? req_m1 : avail);

    always_ff @(posedge clk) begin
        if (rst || clr) hold_q <= 1'b0;
        else            hold_q <= mode1 && req_m1;
    end
endmodule

// File: rtl/ufc_intr.sv
module ufc_intr
    import uart_fc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] rx_level,
    input  logic [LW-1:0] rx_trig,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] tx_thr,
    input  logic          line_err,
    input  logic          timeout_evt,
    input  logic          modem_evt,
    input  logic          busy_evt,
    input  logic          rx_rd,
    input  logic          rx_clr,
    input  logic          tx_wr,
    input  logic          reg_rd,
    output iid_e          iid,
    output logic          irq
);
    logic rda, thre_cond, thre_cond_q, thre_pend, cto_pend;

    assign rda       = rx_level >= rx_trig;
    assign thre_cond = tx_level <= tx_thr;

    always_comb begin
        if (line_err)       iid = IID_RLS;
        else if (rda)       iid = IID_RDA;
        else if (cto_pend)  iid = IID_CTO;
        else if (thre_pend) iid = IID_THRE;
        else if (modem_evt) iid = IID_MODEM;
        else if (busy_evt)  iid = IID_BUSY;
        else                iid = IID_NONE;
    end

    assign irq = iid != IID_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            thre_cond_q <= 1'b1;
            thre_pend   <= 1'b0;
            cto_pend    <= 1'b0;
        end else begin
            thre_cond_q <= thre_cond;
            if (thre_cond && !thre_cond_q)
                thre_pend <= 1'b1;
            else if (tx_wr || (reg_rd && iid == IID_THRE))
                thre_pend <= 1'b0;
            if (timeout_evt)
                cto_pend <= 1'b1;
            else if (rx_rd || rx_clr)
                cto_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fc_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             tx_wr,
    input  logic [WIDTH-1:0] tx_wdata,
    input  logic             tx_pop,
    output logic [WIDTH-1:0] tx_rdata,
    output logic [LW-1:0]    tx_level,
    input  logic             rx_push,
    input  logic [WIDTH-1:0] rx_wdata,
    input  logic             rx_rd,
    output logic [WIDTH-1:0] rx_rdata,
    output logic [LW-1:0]    rx_level,
    input  logic             afc_en,
    input  logic             line_err,
    input  logic             timeout_evt,
    input  logic             modem_evt,
    input  logic             busy_evt,
    output logic             irq,
    output logic             rts_n,
    output logic             dma_tx_req_n,
    output logic             dma_rx_req_n
);
    fcr_t          wr_f;
    logic          fifo_en, dma_m1, toggle, rx_clr, tx_clr;
    logic [1:0]    rx_sel, tx_sel;
    logic [LW-1:0] rx_trig, tx_thr, cap;
    iid_e          iid;

    assign wr_f   = fcr_t'(reg_wdata);
    assign toggle = reg_wr && (wr_f.enable != fifo_en);
    assign rx_clr = (reg_wr && wr_f.rx_clr) || toggle;
    assign tx_clr = (reg_wr && wr_f.tx_clr) || toggle;

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_en <= 1'b0;
            dma_m1  <= 1'b0;
            rx_sel  <= 2'b00;
            tx_sel  <= 2'b00;
        end else if (reg_wr) begin
            fifo_en <= wr_f.enable;
            dma_m1  <= wr_f.dma_mode;
            rx_sel  <= wr_f.rx_trig;
            tx_sel  <= wr_f.tx_thr;
        end
    end

    assign rx_trig = fifo_en ? LW'(rx_trig_count(rx_sel, DEPTH)) : LW'(1);
    assign tx_thr  = fifo_en ? LW'(tx_thr_count(tx_sel, DEPTH))  : '0;
    assign cap     = fifo_en ? LW'(DEPTH) : LW'(1);

    ufc_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .clr(rx_clr), .cap_one(!fifo_en),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_rd),
        .rdata(rx_rdata), .level(rx_level)
    );

    ufc_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst), .clr(tx_clr), .cap_one(!fifo_en),
        .push(tx_wr), .wdata(tx_wdata), .pop(tx_pop),
        .rdata(tx_rdata), .level(tx_level)
    );

    ufc_dma #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx_dma (
        .clk(clk), .rst(rst), .clr(rx_clr), .mode1(dma_m1),
        .level(rx_level), .thresh(rx_trig), .cap(cap), .req_n(dma_rx_req_n)
    );

    ufc_dma #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx_dma (
        .clk(clk), .rst(rst), .clr(tx_clr), .mode1(dma_m1),
        .level(tx_level), .thresh(tx_thr), .cap(cap), .req_n(dma_tx_req_n)
    );

    ufc_intr #(.DEPTH(DEPTH)) u_intr (
        .clk(clk), .rst(rst),
        .rx_level(rx_level), .rx_trig(rx_trig),
        .tx_level(tx_level), .tx_thr(tx_thr),
        .line_err(line_err), .timeout_evt(timeout_evt),
        .modem_evt(modem_evt), .busy_evt(busy_evt),
        .rx_rd(rx_rd), .rx_clr(rx_clr), .tx_wr(tx_wr), .reg_rd(reg_rd),
        .iid(iid), .irq(irq)
    );

    assign reg_rdata = {{2{fifo_en}}, 2'b00, iid};
    assign rts_n     = afc_en && (rx_level >= rx_trig);
endmodule

// File: rtl/ufc_checker.sv
module ufc_checker #(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic [7:0]    reg_wdata,
    input logic [7:0]    reg_rdata,
    input logic [LW-1:0] rx_level,
    input logic [LW-1:0] tx_level,
    input logic          rx_rd,
    input logic          afc_en,
    input logic          line_err,
    input logic          timeout_evt,
    input logic          rts_n,
    input logic          dma_tx_req_n,
    input logic          dma_rx_req_n
);
    p_enable_status_r1: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> reg_rdata[7:6] == {2{$past(reg_wdata[0])}});

    p_line_first_r2: assert property (@(posedge clk) disable iff (rst)
        line_err |-> reg_rdata[3:0] == 4'b0110);

    p_rx_reset_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[1]) |=> rx_level == '0);

    p_tx_reset_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[2]) |=> tx_level == '0);

    p_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[0] != reg_rdata[6]) |=> (rx_level == '0 && tx_level == '0));

    p_cto_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && !timeout_evt) |=> reg_rdata[3:0] != 4'b1100);

    p_rts_off_r8: assert property (@(posedge clk) disable iff (rst)
        !afc_en |-> !rts_n);

    p_rx_empty_r9: assert property (@(posedge clk) disable iff (rst)
        rx_level == '0 |-> dma_rx_req_n);

    p_tx_full_r9: assert property (@(posedge clk) disable iff (rst)
        tx_level == LW'(DEPTH) |-> dma_tx_req_n);

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        rx_level <= LW'(DEPTH) && tx_level <= LW'(DEPTH));
endmodule

bind uart_fifo_ctl ufc_checker #(.DEPTH(DEPTH)) u_checker (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_level(rx_level), .tx_level(tx_level),
    .rx_rd(rx_rd), .afc_en(afc_en), .line_err(line_err),
    .timeout_evt(timeout_evt), .rts_n(rts_n),
    .dma_tx_req_n(dma_tx_req_n), .dma_rx_req_n(dma_rx_req_n)
);

// File: tb/test_uart_fifo_ctl.sv
module test_uart_fifo_ctl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 0, reg_rd = 0, tx_wr = 0, tx_pop = 0, rx_push = 0, rx_rd = 0;
    logic [7:0] reg_wdata = 0, tx_wdata = 0, rx_wdata = 0;
    logic       afc_en = 0, line_err = 0, timeout_evt = 0, modem_evt = 0, busy_evt = 0;
    logic [7:0] reg_rdata, tx_rdata, rx_rdata;
    logic [4:0] tx_level, rx_level;
    logic       irq, rts_n, dma_tx_req_n, dma_rx_req_n;

    int checks = 0, errors = 0;
    int mdl_rx = 0, mdl_tx = 0, cap_b = 1;
    logic en_b = 0;
    logic [7:0] rx_q[$];
    logic [7:0] tx_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_fifo_ctl i_uart_fifo_ctl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_level(tx_level),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_rd(rx_rd),
        .rx_rdata(rx_rdata), .rx_level(rx_level),
        .afc_en(afc_en), .line_err(line_err), .timeout_evt(timeout_evt),
        .modem_evt(modem_evt), .busy_evt(busy_evt), .irq(irq), .rts_n(rts_n),
        .dma_tx_req_n(dma_tx_req_n), .dma_rx_req_n(dma_rx_req_n)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic fcr(input logic [7:0] v);
        if (v[1] || v[0] != en_b) begin rx_q.delete(); mdl_rx = 0; end
        if (v[2] || v[0] != en_b) begin tx_q.delete(); mdl_tx = 0; end
        en_b = v[0];
        cap_b = v[0] ? 16 : 1;
        reg_wr = 1; reg_wdata = v;
        tick();
        reg_wr = 0;
    endtask

    task automatic rxp(input logic [7:0] d);
        if (mdl_rx < cap_b) begin rx_q.push_back(d); mdl_rx++; end
        rx_push = 1; rx_wdata = d;
        tick();
        rx_push = 0;
    endtask

    task automatic rxr();
        rx_rd = 1;
        tick();
        rx_rd = 0;
        if (mdl_rx > 0) mdl_rx--;
    endtask

    task automatic txp(input logic [7:0] d);
        if (mdl_tx < cap_b) begin tx_q.push_back(d); mdl_tx++; end
        tx_wr = 1; tx_wdata = d;
        tick();
        tx_wr = 0;
    endtask

    task automatic txr();
        tx_pop = 1;
        tick();
        tx_pop = 0;
        if (mdl_tx > 0) mdl_tx--;
    endtask

    // Scoreboard monitor: compare each popped head with the expected queue.
    always @(negedge clk) begin
        if (!rst && rx_rd && rx_q.size() > 0) chk("R11 rx order", rx_rdata, rx_q.pop_front());
        if (!rst && tx_pop && tx_q.size() > 0) chk("R11 tx order", tx_rdata, tx_q.pop_front());
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        chk("R1 reset read", reg_rdata, 8'h01);
        chk("R12 reset irq", irq, 0);
        chk("R9 reset tx req", dma_tx_req_n, 0);
        chk("R9 reset rx req", dma_rx_req_n, 1);
        chk("R8 reset rts", rts_n, 0);

        // Disabled: one-entry queues, trigger 1
        rxp(8'hA5); rxp(8'h5A);
        chk("R11 disabled capacity", rx_level, 1);
        chk("R5 disabled trigger", reg_rdata[3:0], 4'b0100);
        chk("R12 irq with rda", irq, 1);
        rxr();
        chk("R11 rx drained", rx_level, 0);

        fcr(8'h01);
        chk("R1 enabled status", reg_rdata[7:6], 2'b11);
        chk("R1 bits 5:4", reg_rdata[5:4], 2'b00);
        rxp(8'h11);
        fcr(8'h01);
        chk("R4 same enable keeps data", rx_level, 1);
        fcr(8'h03);
        chk("R3 rx reset", rx_level, 0);
        rxp(8'h22);
        chk("R3 self clearing", rx_level, 1);
        rxr();

        // Trigger 4 with auto flow control
        fcr(8'h41);
        afc_en = 1;
        for (int i = 0; i < 3; i++) rxp(8'h30 + 8'(i));
        chk("R5 below trigger 4", reg_rdata[3:0], 4'b0001);
        chk("R8 rts below trigger", rts_n, 0);
        rxp(8'h33);
        chk("R5 at trigger 4", reg_rdata[3:0], 4'b0100);
        chk("R8 rts at trigger", rts_n, 1);
        for (int i = 0; i < 4; i++) rxr();

        // Trigger 14, then fill past capacity
        fcr(8'hC1);
        for (int i = 0; i < 13; i++) rxp(8'h40 + 8'(i));
        chk("R5 below trigger 14", reg_rdata[3:0], 4'b0001);
        rxp(8'h4D);
        chk("R5 at trigger 14", reg_rdata[3:0], 4'b0100);
        for (int i = 0; i < 3; i++) rxp(8'h50 + 8'(i));
        chk("R11 full level", rx_level, 16);
        rxp(8'h99);
        chk("R11 push into full ignored", rx_level, 16);
        afc_en = 0;
        #1;
        chk("R8 rts off without afc", rts_n, 0);
        for (int i = 0; i < 16; i++) rxr();

        // Trigger 8 and line error priority
        fcr(8'h81);
        for (int i = 0; i < 7; i++) rxp(8'h60 + 8'(i));
        chk("R5 below trigger 8", reg_rdata[3:0], 4'b0001);
        rxp(8'h67);
        chk("R5 at trigger 8", reg_rdata[3:0], 4'b0100);
        line_err = 1;
        tick();
        chk("R2 line error above rda", reg_rdata[3:0], 4'b0110);
        line_err = 0;
        for (int i = 0; i < 8; i++) rxr();

        // Character timeout
        fcr(8'hC1);
        rxp(8'h71);
        timeout_evt = 1; tick(); timeout_evt = 0;
        chk("R7 timeout pending", reg_rdata[3:0], 4'b1100);
        tick();
        chk("R7 timeout sticky", reg_rdata[3:0], 4'b1100);
        rxr();
        chk("R7 cleared by pop", reg_rdata[3:0], 4'b0001);
        rxp(8'h72);
        timeout_evt = 1; tick(); timeout_evt = 0;
        fcr(8'hC3);
        chk("R7 cleared by rx reset", reg_rdata[3:0], 4'b0001);

        // Transmit empty threshold 2
        fcr(8'h11);
        txp(8'h81); txp(8'h82); txp(8'h83);
        chk("R6 above threshold", reg_rdata[3:0], 4'b0001);
        txr();
        tick();
        chk("R6 crossing sets thre", reg_rdata[3:0], 4'b0010);
        chk("R12 irq thre", irq, 1);
        reg_rd = 1;
        #1;
        chk("R6 read reports thre", reg_rdata[3:0], 4'b0010);
        tick();
        reg_rd = 0;
        chk("R6 cleared by read", reg_rdata[3:0], 4'b0001);
        txr();
        tick();
        chk("R6 no new crossing", reg_rdata[3:0], 4'b0001);
        txp(8'h84); txp(8'h85);
        txr();
        tick();
        chk("R6 second crossing", reg_rdata[3:0], 4'b0010);
        txp(8'h86);
        chk("R6 cleared by push", reg_rdata[3:0], 4'b0001);

        // Modem and busy ordering
        modem_evt = 1; tick();
        chk("R2 modem code", reg_rdata[3:0], 4'b0000);
        busy_evt = 1; tick();
        chk("R2 modem above busy", reg_rdata[3:0], 4'b0000);
        modem_evt = 0; tick();
        chk("R2 busy code", reg_rdata[3:0], 4'b0111);
        busy_evt = 0; tick();
        chk("R12 idle irq", irq, 0);

        // DMA mode 0
        fcr(8'h01);
        chk("R9 rx empty no req", dma_rx_req_n, 1);
        rxp(8'h91);
        chk("R9 rx data req", dma_rx_req_n, 0);
        chk("R9 tx space req", dma_tx_req_n, 0);
        for (int i = 0; i < 13; i++) txp(8'hA0 + 8'(i));
        chk("R11 tx full level", tx_level, 16);
        chk("R9 tx full no req", dma_tx_req_n, 1);

        // DMA mode 1, trigger 4, threshold 0
        fcr(8'h49);
        chk("R10 rx below trigger", dma_rx_req_n, 1);
        rxp(8'h92); rxp(8'h93);
        chk("R10 rx still below", dma_rx_req_n, 1);
        rxp(8'h94);
        chk("R10 rx at trigger", dma_rx_req_n, 0);
        rxr(); rxr(); rxr();
        chk("R10 rx held until empty", dma_rx_req_n, 0);
        rxr();
        chk("R10 rx released on empty", dma_rx_req_n, 1);
        chk("R10 tx full no req", dma_tx_req_n, 1);
        for (int i = 0; i < 15; i++) txr();
        chk("R10 tx above threshold", dma_tx_req_n, 1);
        txr();
        chk("R10 tx at threshold", dma_tx_req_n, 0);
        for (int i = 0; i < 5; i++) txp(8'hC0 + 8'(i));
        chk("R10 tx held while filling", dma_tx_req_n, 0);
        for (int i = 0; i < 11; i++) txp(8'hD0 + 8'(i));
        chk("R10 tx released on full", dma_tx_req_n, 1);
        fcr(8'h05);
        chk("R3 tx reset", tx_level, 0);

        tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule